// File: doc/BRIEF.md
# Interrupt Enable and Mode State Controller

This block keeps the interrupt state of an 8-bit CPU core: a primary enable flip-flop that gates maskable interrupts, a secondary flip-flop that saves the enable state across a non-maskable interrupt, and a 2-bit interrupt mode register. The decoder and the interrupt sequencer send it one-cycle strobes. Each strobe updates that state on the next rising clock edge.

A separate output tells the interrupt sampler whether a maskable request may be taken. That output stays low through the first instruction boundary after an enable instruction, so the instruction that follows the enable always runs before any interrupt. When the core loads the accumulator from the I or R register, the block also works out the flag byte to write back. In that byte the parity/overflow position carries the secondary flip-flop, and a separate signal tells the flag register to keep its carry bit.

Top module: `irq_state_ctl`

## Requirements
- R1: While rst_ni is low and after it is released, both flip-flops are 0, mode_o is 0, mode_unk_o is 0 and int_en_o is 0 until a strobe arrives.
- R2: A disable strobe (di_i) clears iff1_o and iff2_o together after the next rising edge.
- R3: An enable strobe (ei_i) sets iff1_o and iff2_o together after the next rising edge. int_en_o equals iff1_o, except that it is forced to 0 from the edge that takes the enable strobe up to and including the first cycle with bnd_i high. A later enable strobe starts this window again.
- R4: A return-from-interrupt strobe (reti_i) or a return-from-NMI strobe (retn_i) copies iff2_o into iff1_o and leaves iff2_o unchanged.
- R5: A mode-set strobe (im_set_i) loads mode_o from im_sel_i as follows: selector 0 gives 2'd0, selector 1 gives 2'd0, selector 2 gives 2'd1 and selector 3 gives 2'd2.
- R6: mode_unk_o is 1 exactly when the mode register holds 2'd3. No sequence of strobes can reach that value.
- R7: An accepted NMI (nmi_ack_i) clears iff1_o and keeps iff2_o.
- R8: An accepted maskable interrupt (int_ack_i) clears both flip-flops.
- R9: nmi_ack_i wins over int_ack_i. Either of them causes every instruction strobe in the same cycle to be ignored: di_i, ei_i, reti_i, retn_i, im_set_i and ld_ir_i. Among the instruction strobes, di_i wins over ei_i, and ei_i wins over the returns.
- R10: With ld_ir_i high and no accepted event in the same cycle, flag_wr_o and c_keep_o are 1 in that cycle. flag_o then holds: bit 7 = ld_data_i[7], bit 6 = 1 when ld_data_i is zero, bit 2 = the current iff2_o, and bits 5, 4, 3, 1 and 0 = 0. In every other cycle flag_wr_o and c_keep_o are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| bnd_i | input | 1 | Instruction boundary strobe |
| di_i | input | 1 | Disable-interrupts strobe |
| ei_i | input | 1 | Enable-interrupts strobe |
| reti_i | input | 1 | Return-from-interrupt strobe |
| retn_i | input | 1 | Return-from-NMI strobe |
| im_set_i | input | 1 | Set-mode strobe |
| im_sel_i | input | 2 | Mode selector from the opcode |
| nmi_ack_i | input | 1 | NMI accepted |
| int_ack_i | input | 1 | Maskable interrupt accepted |
| ld_ir_i | input | 1 | Accumulator load from I or R |
| ld_data_i | input | 8 | Byte being transferred |
| iff1_o | output | 1 | Primary enable flip-flop |
| iff2_o | output | 1 | Secondary enable flip-flop |
| mode_o | output | 2 | Interrupt mode |
| mode_unk_o | output | 1 | Mode register holds an illegal value |
| int_en_o | output | 1 | Maskable interrupts may be sampled |
| flag_wr_o | output | 1 | Flag byte is valid for writing |
| flag_o | output | 8 | Flag byte for the I/R load |
| c_keep_o | output | 1 | Keep the carry flag during the write |

## Verification
Two things can land in the same cycle. An accepted NMI or maskable interrupt can arrive together with decoded instruction strobes, and an I/R load can arrive together with a flip-flop update. The bench sets up every reachable flip-flop state, including a pending enable delay, and each interrupt mode. From each of these it applies all 2048 combinations of the strobes and the selector. It judges the flag byte in the same cycle against the state held before the edge, and the registered state after the edge against the priority order of R9.

// File: rtl/irq_state_pkg.sv
package irq_state_pkg;

  typedef enum logic [1:0] {
    IM_0 = 2'd0,
    IM_1 = 2'd1,
    IM_2 = 2'd2,
    IM_X = 2'd3
  } im_e;

  // resolved one-hot-ish command after priority
  typedef struct packed {
    logic evt_nmi;
    logic evt_int;
    logic op_di;
    logic op_ei;
    logic op_ret;
    logic op_im;
    logic op_ld;
  } iff_cmd_t;

  localparam int unsigned FLG_S  = 7;
  localparam int unsigned FLG_Z  = 6;
  localparam int unsigned FLG_H  = 4;
  localparam int unsigned FLG_PV = 2;
  localparam int unsigned FLG_N  = 1;
  localparam int unsigned FLG_C  = 0;

  function automatic im_e sel_to_mode(input logic [1:0] sel);
    im_e m;
    unique case (sel)
      2'd0, 2'd1: m = IM_0;
      2'd2:       m = IM_1;
      default:    m = IM_2;
    endcase
    return m;
  endfunction

endpackage

// File: rtl/irq_iff_ctrl.sv
module irq_iff_ctrl
  import irq_state_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  iff_cmd_t cmd_i,
  input  logic     bnd_i,
  output logic     iff1_o,
  output logic     iff2_o,
  output logic     int_en_o
);

  logic iff1_q, iff2_q, pend_q;
  logic iff1_d, iff2_d, pend_d;

  always_comb begin
    iff1_d = iff1_q;
    iff2_d = iff2_q;
    if (cmd_i.evt_nmi) begin
      iff1_d = 1'b0;
    end else if (cmd_i.evt_int) begin
      iff1_d = 1'b0;
      iff2_d = 1'b0;
    end else if (cmd_i.op_di) begin
      iff1_d = 1'b0;
      iff2_d = 1'b0;
    end else if (cmd_i.op_ei) begin
      iff1_d = 1'b1;
      iff2_d = 1'b1;
    end else if (cmd_i.op_ret) begin
      iff1_d = iff2_q;
    end
  end

  // one-boundary shadow after EI
  always_comb begin
    if (cmd_i.op_ei)  pend_d = 1'b1;
    else if (bnd_i)   pend_d = 1'b0;
    else              pend_d = pend_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      iff1_q <= 1'b0;
      iff2_q <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      iff1_q <= iff1_d;
      iff2_q <= iff2_d;
      pend_q <= pend_d;
    end
  end

  assign iff1_o   = iff1_q;
  assign iff2_o   = iff2_q;
  assign int_en_o = iff1_q & ~pend_q;

endmodule

// File: rtl/irq_mode_reg.sv
module irq_mode_reg
  import irq_state_pkg::*;
#(
  parameter int unsigned SEL_W = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_i,
  input  logic [SEL_W-1:0] sel_i,
  output logic [1:0]       mode_o,
  output logic             unk_o
);

  im_e mode_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   mode_q <= IM_0;
    else if (wr_i) mode_q <= sel_to_mode(sel_i[1:0]);
  end

  assign mode_o = mode_q;
  assign unk_o  = (mode_q == IM_X);

endmodule

// File: rtl/irq_ldir_flags.sv
module irq_ldir_flags
  import irq_state_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic              wr_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              iff2_i,
  output logic              wr_o,
  output logic [7:0]        flag_o,
  output logic              c_keep_o
);

  always_comb begin
    flag_o         = '0;
    flag_o[FLG_S]  = data_i[DATA_W-1];
    flag_o[FLG_Z]  = ~|data_i;
    flag_o[FLG_H]  = 1'b0;
    flag_o[FLG_PV] = iff2_i;
    flag_o[FLG_N]  = 1'b0;
    flag_o[FLG_C]  = 1'b0;
  end

  assign wr_o     = wr_i;
  assign c_keep_o = wr_i;

endmodule

// File: rtl/irq_state_ctl.sv
module irq_state_ctl
  import irq_state_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned SEL_W  = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bnd_i,
  input  logic              di_i,
  input  logic              ei_i,
  input  logic              reti_i,
  input  logic              retn_i,
  input  logic              im_set_i,
  input  logic [SEL_W-1:0]  im_sel_i,
  input  logic              nmi_ack_i,
  input  logic              int_ack_i,
  input  logic              ld_ir_i,
  input  logic [DATA_W-1:0] ld_data_i,
  output logic              iff1_o,
  output logic              iff2_o,
  output logic [1:0]        mode_o,
  output logic              mode_unk_o,
  output logic              int_en_o,
  output logic              flag_wr_o,
  output logic [7:0]        flag_o,
  output logic              c_keep_o
);

  iff_cmd_t cmd;
  logic     no_evt;

  // events beat instruction strobes; DI > EI > returns
  always_comb begin
    no_evt      = ~nmi_ack_i & ~int_ack_i;
    cmd.evt_nmi = nmi_ack_i;
    cmd.evt_int = int_ack_i & ~nmi_ack_i;
    cmd.op_di   = no_evt & di_i;
    cmd.op_ei   = no_evt & ~di_i & ei_i;
    cmd.op_ret  = no_evt & ~di_i & ~ei_i & (reti_i | retn_i);
    cmd.op_im   = no_evt & im_set_i;
    cmd.op_ld   = no_evt & ld_ir_i;
  end

  irq_iff_ctrl u_iff (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .cmd_i    (cmd),
    .bnd_i    (bnd_i),
    .iff1_o   (iff1_o),
    .iff2_o   (iff2_o),
    .int_en_o (int_en_o)
  );

  irq_mode_reg #(.SEL_W(SEL_W)) u_mode (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .wr_i   (cmd.op_im),
    .sel_i  (im_sel_i),
    .mode_o (mode_o),
    .unk_o  (mode_unk_o)
  );

  irq_ldir_flags #(.DATA_W(DATA_W)) u_flags (
    .wr_i     (cmd.op_ld),
    .data_i   (ld_data_i),
    .iff2_i   (iff2_o),
    .wr_o     (flag_wr_o),
    .flag_o   (flag_o),
    .c_keep_o (c_keep_o)
  );

endmodule

// File: rtl/irq_state_ctl_chk.sv
module irq_state_ctl_chk #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned SEL_W  = 2
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              bnd_i,
  input logic              di_i,
  input logic              ei_i,
  input logic              reti_i,
  input logic              retn_i,
  input logic              im_set_i,
  input logic [SEL_W-1:0]  im_sel_i,
  input logic              nmi_ack_i,
  input logic              int_ack_i,
  input logic              ld_ir_i,
  input logic [DATA_W-1:0] ld_data_i,
  input logic              iff1_o,
  input logic              iff2_o,
  input logic [1:0]        mode_o,
  input logic              mode_unk_o,
  input logic              int_en_o,
  input logic              flag_wr_o,
  input logic [7:0]        flag_o,
  input logic              c_keep_o
);

  logic quiet, ei_tk, ret_tk;
  assign quiet  = ~nmi_ack_i & ~int_ack_i;
  assign ei_tk  = quiet & ei_i & ~di_i;
  assign ret_tk = quiet & ~di_i & ~ei_i & (reti_i | retn_i);

  a_r1_en_needs_iff1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int_en_o |-> iff1_o);

  a_r2_di_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (quiet && di_i) |=> (!iff1_o && !iff2_o));

  a_r3_ei_sets: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ei_tk |=> (iff1_o && iff2_o));

  a_r3_ei_shadow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bnd_i && $past(ei_tk)) |-> !int_en_o);

  a_r4_ret_copy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ret_tk |=> (iff1_o == $past(iff2_o) && iff2_o == $past(iff2_o)));

  a_r5_sel1_mode0: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (quiet && im_set_i && im_sel_i == 2'd1) |=> (mode_o == 2'd0));

  a_r6_mode_legal: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mode_unk_o && mode_o != 2'd3);

  a_r7_nmi_keeps_iff2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    nmi_ack_i |=> (!iff1_o && iff2_o == $past(iff2_o)));

  a_r8_int_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (int_ack_i && !nmi_ack_i) |=> (!iff1_o && !iff2_o));

  a_r9_evt_blocks_ld: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (nmi_ack_i || int_ack_i) |-> (!flag_wr_o && !c_keep_o));

  a_r9_evt_blocks_mode: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (nmi_ack_i || int_ack_i) |=> $stable(mode_o));

  a_r10_pv_is_iff2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flag_wr_o |-> (flag_o[2] == iff2_o && c_keep_o && flag_o[1:0] == 2'b00));

endmodule

bind irq_state_ctl irq_state_ctl_chk #(.DATA_W(DATA_W), .SEL_W(SEL_W)) u_chk (.*);

// File: tb/irq_state_ctl_tb_top.sv
`timescale 1ns/1ps
module irq_state_ctl_tb_top;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       bnd_i = 0, di_i = 0, ei_i = 0, reti_i = 0, retn_i = 0, im_set_i = 0;
  logic [1:0] im_sel_i = 0;
  logic       nmi_ack_i = 0, int_ack_i = 0, ld_ir_i = 0;
  logic [7:0] ld_data_i = 0;
  logic       iff1_o, iff2_o, mode_unk_o, int_en_o, flag_wr_o, c_keep_o;
  logic [1:0] mode_o;
  logic [7:0] flag_o;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  logic m_iff1 = 0, m_iff2 = 0, m_pend = 0;
  logic [1:0] m_mode = 0;

  always #2 clk_i = ~clk_i;

  irq_state_ctl dut_i (.*);

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  // v: [0]bnd [1]di [2]ei [3]reti [4]retn [5]im_set [6]nmi [7]int [8]ld [10:9]sel
  task automatic cyc(input logic [10:0] v, input logic [7:0] d);
    logic quiet, ld_ok, ei_tk;
    logic [7:0] ef;
    string lbl;
    @(negedge clk_i);
    {im_sel_i, ld_ir_i, int_ack_i, nmi_ack_i, im_set_i, retn_i, reti_i, ei_i, di_i, bnd_i} = v;
    ld_data_i = d;
    #1;
    quiet = !v[6] && !v[7];
    ld_ok = v[8] && quiet;
    check("R10 flag_wr", {7'd0, flag_wr_o}, {7'd0, ld_ok});
    check("R10 c_keep", {7'd0, c_keep_o}, {7'd0, ld_ok});
    if (ld_ok) begin
      ef = 8'h00;
      ef[7] = d[7];
      ef[6] = (d == 8'h00);
      ef[2] = m_iff2;
      check("R10 flags", flag_o, ef);
    end
    check("R3 int_en", {7'd0, int_en_o}, {7'd0, m_iff1 & ~m_pend});
    // reference update
    ei_tk = quiet && !v[1] && v[2];
    if (v[6]) m_iff1 = 0;
    else if (v[7]) begin m_iff1 = 0; m_iff2 = 0; end
    else if (v[1]) begin m_iff1 = 0; m_iff2 = 0; end
    else if (v[2]) begin m_iff1 = 1; m_iff2 = 1; end
    else if (v[3] || v[4]) m_iff1 = m_iff2;
    if (quiet && v[5]) m_mode = (v[10:9] == 2'd0) ? 2'd0 : 2'(v[10:9] - 2'd1);
    if (ei_tk) m_pend = 1;
    else if (v[0]) m_pend = 0;
    if (!quiet && (v[5:1] != 0 || v[8])) lbl = "R9";
    else if (v[6] && v[7]) lbl = "R9";
    else if (v[6]) lbl = "R7";
    else if (v[7]) lbl = "R8";
    else if (v[1] && (v[2] || v[3] || v[4])) lbl = "R9";
    else if (v[1]) lbl = "R2";
    else if (v[2]) lbl = "R3";
    else if (v[3] || v[4]) lbl = "R4";
    else lbl = "R9";
    @(posedge clk_i);
    #1;
    check({lbl, " iff"}, {6'd0, iff1_o, iff2_o}, {6'd0, m_iff1, m_iff2});
    check("R5 mode", {6'd0, mode_o}, {6'd0, m_mode});
    check("R6 unk", {7'd0, mode_unk_o}, 8'd0);
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog act=running exp=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #5;
    // R1 reset state
    check("R1 iff in reset", {6'd0, iff1_o, iff2_o}, 8'd0);
    check("R1 mode in reset", {6'd0, mode_o}, 8'd0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    @(posedge clk_i); #1;
    check("R1 iff after reset", {6'd0, iff1_o, iff2_o}, 8'd0);
    check("R1 mode after reset", {6'd0, mode_o}, 8'd0);
    check("R1 unk after reset", {7'd0, mode_unk_o}, 8'd0);
    check("R1 int_en after reset", {7'd0, int_en_o}, 8'd0);

    // directed: EI shadow spans boundaries
    cyc(11'h004, 8'h00);          // EI
    cyc(11'h000, 8'h00);          // idle, shadow held
    cyc(11'h001, 8'h00);          // boundary, still suppressed
    cyc(11'h000, 8'h00);          // now enabled
    check("R3 enabled after boundary", {7'd0, int_en_o}, 8'd1);

    for (int ms = 0; ms < 3; ms++) begin
      for (int cfg = 0; cfg < 4; cfg++) begin
        for (int c = 0; c < 2048; c++) begin
          logic [1:0] sel;
          logic [7:0] dd;
          sel = (ms == 0) ? 2'd0 : 2'(ms + 1);
          cyc({sel, 9'h020}, 8'h00);
          case (cfg)
            0: cyc(11'h002, 8'h00);
            1: cyc(11'h004, 8'h00);
            2: begin cyc(11'h004, 8'h00); cyc(11'h001, 8'h00); end
            default: begin cyc(11'h004, 8'h00); cyc(11'h040, 8'h00); end
          endcase
          dd = (c[3:0] == 4'd0) ? 8'h00 : 8'(c * 37 + cfg * 11 + ms);
          cyc(11'(c), dd);
        end
      end
    end
    cyc(11'h000, 8'h00);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule